// File: doc/BRIEF.md
# Asynchronous Serial Port with Byte Queues

This block is a full-duplex asynchronous serial port that a host drives through a small register window. The window has a 3-bit register offset, an 8-bit data path, and separate read and write strobes. Bytes written to the data offset queue up in a 16-entry transmit buffer. The transmitter sends them as frames of start bit, 5 to 8 data bits, an optional parity bit and a stop period. The receiver oversamples the incoming line at sixteen ticks per bit and places each byte it assembles in a 16-entry receive buffer. It reports line faults in a status register.

A 16-bit divisor sets the rate. The oversampling tick fires once every divisor clocks, and one bit lasts sixteen ticks. A frame-format register sets the word length, parity, stop period and break. One bit in that register swaps the first two offsets over to the divisor bytes. A single interrupt line reports received data and an empty transmit buffer.

Top module: `sio_uart`

## Requirements
- R1: The register offsets are: 0 = receive data on read and transmit data on write, 1 = interrupt enable, 2 = buffer control, 3 = frame format, 5 = line status. While frame-format bit 7 is 1, offsets 0 and 1 read and write the low and high divisor bytes instead, and a read of offset 0 removes nothing from the receive buffer.
- R2: The oversampling tick fires once every divisor clocks, and each serial bit lasts 16 ticks. A divisor of 0 stops the tick.
- R3: Frame-format bits [1:0] select 5, 6, 7 or 8 data bits (codes 00 to 11). A frame starts with a low start bit, and data bits go out least significant bit first. Data bits above the word length are neither sent nor received.
- R4: Frame-format bit 3 enables a parity bit, and bit 4 selects even parity (1) or odd parity (0). With bit 5 also set, the parity position carries a constant: 0 when bit 4 is 1, and 1 when bit 4 is 0.
- R5: With frame-format bit 2 clear, the stop period is one bit (16 ticks). With bit 2 set, it is 24 ticks for 5-bit words and 32 ticks for longer words. Queued bytes go out back to back, so consecutive start edges are exactly one frame apart.
- R6: While frame-format bit 6 is 1, the serial output stays low. The output returns to idle high once the bit is cleared.
- R7: Each buffer holds 16 bytes. Buffer-control bit 0 enables the buffers (after reset they are disabled and hold one byte each). Writing 1 to bit 1 empties the receive buffer, and writing 1 to bit 2 empties the transmit buffer. A write that changes bit 0 empties both.
- R8: A falling edge on the receive line starts a frame only if the line is still low at the 8th tick after the edge. Later bits are sampled every 16 ticks from that point. Shorter low pulses are ignored.
- R9: Line-status bit 0 is data ready (receive buffer not empty). Bit 5 means the transmit buffer is empty. Bit 6 means the transmit buffer is empty and the shifter is idle. Bit 7 reads 0.
- R10: Line-status bit 2 flags a parity mismatch. Bit 3 flags a stop bit sampled low in a frame that is not all zero. Bit 4 flags a break, meaning data, parity and stop all sampled low. These flags stay set until the line status is read, and the read clears them. After a frame ends low, reception resumes only after the line has returned high.
- R11: Line-status bit 1 sets when a frame completes while the receive buffer is full. The new byte is dropped, and the bytes already held are kept in order. The bit clears on a line-status read.
- R12: Interrupt-enable bit 0 arms data ready and bit 1 arms transmit-buffer-empty. The interrupt output is the registered OR of the armed conditions.
- R13: A synchronous active-high reset leaves the serial output high, the interrupt low, the frame format at 0x00, and the line status at 0x60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Host write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
Most wrong internal state shows up on the serial pins within one frame. A bad bit counter or stop length changes the spacing of start edges, which is measured to the exact clock. A bad parity rule shows in the parity bit sampled at mid-bit. A receiver fault reaches the host at the next line-status or data read, either as a flag set with no cause or as a byte that differs from the one driven. Buffer pointer or depth faults appear within 17 frames, as a reordered byte, a missing overrun or a lost byte.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DIV_W = 16;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IEN  = 3'd1;
  localparam logic [2:0] OFS_BUF  = 3'd2;
  localparam logic [2:0] OFS_FMT  = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd5;

  typedef struct packed {
    logic       stick;
    logic       even;
    logic       par_en;
    logic       long_stop;
    logic [1:0] wlen;
  } frm_t;

  typedef struct packed {
    logic dlab;
    logic brk;
    frm_t frm;
  } fmt_t;

  function automatic logic [7:0] word_mask(input logic [1:0] wl);
    return 8'hFF >> (2'd3 - wl);
  endfunction

  function automatic logic parity_of(input logic even, input logic stick,
                                     input logic [1:0] wl, input logic [7:0] d);
    logic x;
    x = ^(d & word_mask(wl));
    if (stick) return ~even;
    return even ? x : ~x;
  endfunction
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             one_deep,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CNTW-1:0]  cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = one_deep ? (cnt != '0) : (cnt == CNTW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  frm_t       frm,
  input  logic       brk,
  input  logic       have_data,
  input  logic [7:0] din,
  output logic       take,
  output logic       txd,
  output logic       busy
);
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_t;

  tst_t       st;
  logic [4:0] tcnt;
  logic [7:0] sh, word_q;
  logic [2:0] left;
  logic       line;
  logic [2:0] last_idx;
  logic [4:0] stop_last;
  logic       bit_end, stop_end;

  assign last_idx  = 3'd4 + {1'b0, frm.wlen};
  assign stop_last = !frm.long_stop ? 5'd15 : ((frm.wlen == 2'd0) ? 5'd23 : 5'd31);
  assign bit_end   = tick && (tcnt == 5'd15);
  assign stop_end  = tick && (tcnt == stop_last);
  assign take      = have_data && ((st == T_IDLE) || (st == T_STOP && stop_end));
  assign busy      = (st != T_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= T_IDLE;
      tcnt   <= '0;
      sh     <= '0;
      word_q <= '0;
      left   <= '0;
      line   <= 1'b1;
    end else begin
      if (tick) tcnt <= tcnt + 1'b1;
      case (st)
        T_IDLE: begin
          line <= 1'b1;
          if (have_data) begin
            sh     <= din;
            word_q <= din;
            tcnt   <= '0;
            line   <= 1'b0;
            st     <= T_START;
          end
        end
        T_START: if (bit_end) begin
          tcnt <= '0;
          line <= sh[0];
          left <= last_idx;
          st   <= T_DATA;
        end
        T_DATA: if (bit_end) begin
          tcnt <= '0;
          if (left == '0) begin
            if (frm.par_en) begin
              line <= parity_of(frm.even, frm.stick, frm.wlen, word_q);
              st   <= T_PAR;
            end else begin
              line <= 1'b1;
              st   <= T_STOP;
            end
          end else begin
            sh   <= sh >> 1;
            line <= sh[1];
            left <= left - 1'b1;
          end
        end
        T_PAR: if (bit_end) begin
          tcnt <= '0;
          line <= 1'b1;
          st   <= T_STOP;
        end
        default: if (stop_end) begin
          tcnt <= '0;
          if (have_data) begin
            sh     <= din;
            word_q <= din;
            line   <= 1'b0;
            st     <= T_START;
          end else begin
            line <= 1'b1;
            st   <= T_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else     txd <= brk ? 1'b0 : line;
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       even,
  input  logic       stick,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] data,
  output logic       pe,
  output logic       fe,
  output logic       bi
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_WAIT} rst_t;

  rst_t       st;
  logic       rs1, rs2;
  logic [3:0] tcnt;
  logic [2:0] left;
  logic [7:0] sh;
  logic       pbit;
  logic       mid;
  logic [7:0] word;
  logic       all_low;

  assign mid     = tick && (tcnt == 4'd15);
  assign word    = sh >> (2'd3 - wlen);
  assign all_low = (word == 8'h00) && (!par_en || !pbit) && !rs2;

  always_ff @(posedge clk) begin
    if (rst) begin
      rs1 <= 1'b1;
      rs2 <= 1'b1;
    end else begin
      rs1 <= rxd;
      rs2 <= rs1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= R_IDLE;
      tcnt <= '0;
      left <= '0;
      sh   <= '0;
      pbit <= 1'b0;
      done <= 1'b0;
      data <= '0;
      pe   <= 1'b0;
      fe   <= 1'b0;
      bi   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) tcnt <= tcnt + 1'b1;
      case (st)
        R_IDLE: if (!rs2) begin
          tcnt <= '0;
          st   <= R_START;
        end
        R_START: if (tick && tcnt == 4'd7) begin
          tcnt <= '0;
          left <= 3'd4 + {1'b0, wlen};
          st   <= rs2 ? R_IDLE : R_DATA;
        end
        R_DATA: if (mid) begin
          sh <= {rs2, sh[7:1]};
          if (left == '0) st <= par_en ? R_PAR : R_STOP;
          else            left <= left - 1'b1;
        end
        R_PAR: if (mid) begin
          pbit <= rs2;
          st   <= R_STOP;
        end
        R_STOP: if (mid) begin
          done <= 1'b1;
          data <= word;
          pe   <= par_en && (pbit != parity_of(even, stick, wlen, word));
          bi   <= all_low;
          fe   <= !rs2 && !all_low;
          st   <= rs2 ? R_IDLE : R_WAIT;
        end
        default: if (rs2) st <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sio_uart.sv
module sio_uart
  import sio_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  fmt_t             fmt_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       ien_q;
  logic             buf_en_q;
  logic             oe_q, pe_q, fe_q, bi_q;

  logic             tick, div_wr;
  logic             tx_push, tx_take, tx_empty, tx_full, tx_busy, tx_clr;
  logic [7:0]       tx_dout;
  logic             rx_done, rx_pe, rx_fe, rx_bi, rx_pop, rx_empty, rx_full, rx_clr;
  logic [7:0]       rx_data, rx_dout;
  logic             stat_rd, rx_dr;
  logic [7:0]       stat;

  assign div_wr  = wr_en && fmt_q.dlab && (addr == OFS_DATA || addr == OFS_IEN);
  assign tx_push = wr_en && !fmt_q.dlab && (addr == OFS_DATA);
  assign rx_pop  = rd_en && !fmt_q.dlab && (addr == OFS_DATA);
  assign stat_rd = rd_en && (addr == OFS_STAT);
  assign tx_clr  = wr_en && (addr == OFS_BUF) && (wdata[2] || (wdata[0] != buf_en_q));
  assign rx_clr  = wr_en && (addr == OFS_BUF) && (wdata[1] || (wdata[0] != buf_en_q));
  assign rx_dr   = !rx_empty;
  assign stat    = {1'b0, tx_empty && !tx_busy, tx_empty, bi_q, fe_q, pe_q, oe_q, rx_dr};

  sio_baud #(.DW(DIV_W)) baud_i (
    .clk(clk), .rst(rst), .restart(div_wr), .div(div_q), .tick(tick)
  );

  sio_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) txq_i (
    .clk(clk), .rst(rst), .clr(tx_clr), .one_deep(!buf_en_q),
    .push(tx_push), .din(wdata), .pop(tx_take), .dout(tx_dout),
    .empty(tx_empty), .full(tx_full)
  );

  sio_tx tx_i (
    .clk(clk), .rst(rst), .tick(tick), .frm(fmt_q.frm), .brk(fmt_q.brk),
    .have_data(!tx_empty), .din(tx_dout), .take(tx_take), .txd(txd), .busy(tx_busy)
  );

  sio_rx rx_i (
    .clk(clk), .rst(rst), .tick(tick), .wlen(fmt_q.frm.wlen),
    .par_en(fmt_q.frm.par_en), .even(fmt_q.frm.even), .stick(fmt_q.frm.stick),
    .rxd(rxd), .done(rx_done), .data(rx_data), .pe(rx_pe), .fe(rx_fe), .bi(rx_bi)
  );

  sio_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rxq_i (
    .clk(clk), .rst(rst), .clr(rx_clr), .one_deep(!buf_en_q),
    .push(rx_done), .din(rx_data), .pop(rx_pop), .dout(rx_dout),
    .empty(rx_empty), .full(rx_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q    <= '0;
      div_q    <= '0;
      ien_q    <= '0;
      buf_en_q <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        OFS_DATA: if (fmt_q.dlab) div_q[7:0] <= wdata;
        OFS_IEN:  if (fmt_q.dlab) div_q[DIV_W-1:8] <= wdata[DIV_W-9:0];
                  else            ien_q <= wdata[1:0];
        OFS_BUF:  buf_en_q <= wdata[0];
        OFS_FMT:  fmt_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= 1'b0;
      pe_q <= 1'b0;
      fe_q <= 1'b0;
      bi_q <= 1'b0;
    end else begin
      oe_q <= (rx_done && rx_full) || (oe_q && !stat_rd);
      pe_q <= (rx_done && rx_pe)   || (pe_q && !stat_rd);
      fe_q <= (rx_done && rx_fe)   || (fe_q && !stat_rd);
      bi_q <= (rx_done && rx_bi)   || (bi_q && !stat_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= (ien_q[0] && rx_dr) || (ien_q[1] && tx_empty);
      if (rd_en) begin
        case (addr)
          OFS_DATA: rdata <= fmt_q.dlab ? div_q[7:0] : rx_dout;
          OFS_IEN:  rdata <= fmt_q.dlab ? div_q[DIV_W-1:8] : {6'b0, ien_q};
          OFS_BUF:  rdata <= {7'b0, buf_en_q};
          OFS_FMT:  rdata <= fmt_q;
          OFS_STAT: rdata <= stat;
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_uart_chk.sv
module sio_uart_chk (
  input logic       clk,
  input logic       rst,
  input logic       txd,
  input logic       irq,
  input logic       brk,
  input logic       tx_busy,
  input logic [1:0] ien,
  input logic       dr,
  input logic       rx_push,
  input logic       rx_full,
  input logic       oe,
  input logic       pe,
  input logic       fe,
  input logic       bi,
  input logic       stat_rd
);
  assert_break_low_R6: assert property (@(posedge clk) disable iff (rst)
    brk |=> !txd);

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
    (!brk && !$past(brk) && !tx_busy && !$past(tx_busy)) |-> txd);

  assert_overrun_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full) |=> oe);

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !rx_push) |=> !(pe || fe || bi || oe));

  assert_irq_mask_R12: assert property (@(posedge clk) disable iff (rst)
    (ien == 2'b00) |=> !irq);

  assert_irq_data_R12: assert property (@(posedge clk) disable iff (rst)
    (ien[0] && dr) |=> irq);
endmodule

bind sio_uart sio_uart_chk chk_i (
  .clk(clk), .rst(rst), .txd(txd), .irq(irq), .brk(fmt_q.brk), .tx_busy(tx_busy),
  .ien(ien_q), .dr(rx_dr), .rx_push(rx_done), .rx_full(rx_full), .oe(oe_q),
  .pe(pe_q), .fe(fe_q), .bi(bi_q), .stat_rd(stat_rd)
);

// File: tb/sio_uart_tb_top.sv
module sio_uart_tb_top;
  localparam int DIV = 3;
  localparam int BIT = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata;
  logic       rxd = 1'b1;
  logic       txd, irq;

  int    checks = 0, errors = 0;
  longint cyc = 0;
  bit    finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sio_uart dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input logic [7:0] cfg);
    logic [7:0] m = 8'h00;
    for (int i = 0; i < 5 + int'(cfg[1:0]); i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic exp_par(input logic [7:0] cfg, input logic [7:0] d);
    int ones = 0;
    logic [7:0] md = d & mask_of(cfg);
    for (int i = 0; i < 8; i++) ones += int'(md[i]);
    if (cfg[5]) return !cfg[4];
    return cfg[4] ? logic'(ones % 2) : !logic'(ones % 2);
  endfunction

  function automatic longint frame_cycles(input logic [7:0] cfg);
    int stop_ticks = !cfg[2] ? 16 : ((cfg[1:0] == 2'b00) ? 24 : 32);
    return longint'((1 + 5 + int'(cfg[1:0]) + int'(cfg[3])) * BIT + stop_ticks * DIV);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic [7:0] cfg,
                         input bit bad_par, input bit bad_stop);
    rxd = 1'b0; idle(BIT);
    for (int i = 0; i < 5 + int'(cfg[1:0]); i++) begin rxd = d[i]; idle(BIT); end
    if (cfg[3]) begin rxd = exp_par(cfg, d) ^ bad_par; idle(BIT); end
    rxd = !bad_stop; idle(BIT);
    rxd = 1'b1; idle(BIT);
  endtask

  task automatic get_tx(input logic [7:0] cfg, output logic [7:0] d, output logic p,
                        output logic s, output longint t);
    while (txd !== 1'b0) @(negedge clk);
    t = cyc; d = 8'h00; p = 1'b0;
    idle(BIT / 2);
    for (int i = 0; i < 5 + int'(cfg[1:0]); i++) begin idle(BIT); d[i] = txd; end
    if (cfg[3]) begin idle(BIT); p = txd; end
    idle(BIT); s = txd;
  endtask

  task automatic wait_tx_done();
    logic [7:0] v;
    do rd(3'd5, v); while (!v[6]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, cfg, b0, b1, b2, d, rb;
    logic [7:0] held [16];
    logic p, s;
    longint t0, t1, t2;
    void'($urandom(32'd7311));

    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    chk(txd === 1'b1, "R13 txd idle", int'(txd), 1);
    chk(irq === 1'b0, "R13 irq", int'(irq), 0);
    rd(3'd5, v); chk(v == 8'h60, "R13 R9 status after reset", v, 8'h60);
    rd(3'd3, v); chk(v == 8'h00, "R13 format after reset", v, 0);

    wr(3'd3, 8'h80); wr(3'd0, 8'(DIV)); wr(3'd1, 8'h00);
    rd(3'd0, v); chk(v == 8'(DIV), "R1 divisor low readback", v, DIV);
    rd(3'd1, v); chk(v == 8'h00, "R1 divisor high readback", v, 0);
    wr(3'd3, 8'h03);

    // buffers disabled after reset: one byte deep
    send_rx(8'hA5, 8'h03, 0, 0);
    send_rx(8'h3C, 8'h03, 0, 0);
    rd(3'd5, v); chk((v & 8'h1F) == 8'h03, "R7 R11 one-deep overrun", v & 8'h1F, 3);
    rd(3'd0, v); chk(v == 8'hA5, "R7 one-deep keeps first", v, 8'hA5);
    wr(3'd2, 8'h07);

    for (int it = 0; it < 8; it++) begin
      cfg = {2'b00, 6'($urandom_range(0, 63))};
      wr(3'd3, cfg);
      b0 = 8'($urandom); b1 = 8'($urandom); b2 = 8'($urandom);
      wr(3'd0, b0); wr(3'd0, b1); wr(3'd0, b2);
      get_tx(cfg, d, p, s, t0);
      chk(d == (b0 & mask_of(cfg)), "R3 tx data", d, b0 & mask_of(cfg));
      get_tx(cfg, d, p, s, t1);
      chk(d == (b1 & mask_of(cfg)), "R3 tx data", d, b1 & mask_of(cfg));
      if (cfg[3]) chk(p == exp_par(cfg, b1), "R4 tx parity", int'(p), int'(exp_par(cfg, b1)));
      chk(s == 1'b1, "R5 stop level", int'(s), 1);
      get_tx(cfg, d, p, s, t2);
      chk(d == (b2 & mask_of(cfg)), "R3 tx data", d, b2 & mask_of(cfg));
      chk((t2 - t1) == frame_cycles(cfg), "R5 R2 frame spacing",
          int'(t2 - t1), int'(frame_cycles(cfg)));
      wait_tx_done();
      rd(3'd5, v); chk(v == 8'h60, "R9 idle status", v, 8'h60);
      rb = 8'($urandom);
      send_rx(rb, cfg, 0, 0);
      rd(3'd5, v); chk((v & 8'h1F) == 8'h01, "R9 R10 clean receive", v & 8'h1F, 1);
      rd(3'd0, v); chk(v == (rb & mask_of(cfg)), "R3 R4 rx data", v, rb & mask_of(cfg));
    end

    wr(3'd3, 8'h03);
    rxd = 1'b0; idle(3 * DIV); rxd = 1'b1; idle(2 * BIT);
    rd(3'd5, v); chk(v[0] == 1'b0, "R8 short pulse ignored", int'(v[0]), 0);

    wr(3'd3, 8'h1B);
    send_rx(8'h6E, 8'h1B, 1, 0);
    rd(3'd5, v); chk((v & 8'h1F) == 8'h05, "R10 parity error", v & 8'h1F, 5);
    rd(3'd5, v); chk((v & 8'h1E) == 8'h00, "R10 cleared by read", v & 8'h1E, 0);
    rd(3'd0, v); chk(v == 8'h6E, "R10 data with parity error", v, 8'h6E);

    wr(3'd3, 8'h03);
    send_rx(8'h5A, 8'h03, 0, 1);
    rd(3'd5, v); chk((v & 8'h1F) == 8'h09, "R10 framing error", v & 8'h1F, 9);
    rd(3'd0, v); chk(v == 8'h5A, "R10 data with framing error", v, 8'h5A);

    rxd = 1'b0; idle(BIT * 25); rxd = 1'b1; idle(2 * BIT);
    rd(3'd5, v); chk((v & 8'h1F) == 8'h11, "R10 break", v & 8'h1F, 8'h11);
    rd(3'd0, v); chk(v == 8'h00, "R10 break byte", v, 0);
    rd(3'd5, v); chk(v[0] == 1'b0, "R10 single byte per break", int'(v[0]), 0);

    for (int i = 0; i < 17; i++) begin
      rb = 8'($urandom);
      if (i < 16) held[i] = rb;
      send_rx(rb, 8'h03, 0, 0);
    end
    rd(3'd5, v); chk((v & 8'h03) == 8'h03, "R11 overrun at depth 16", v & 8'h03, 3);
    for (int i = 0; i < 16; i++) begin
      rd(3'd0, v); chk(v == held[i], "R7 R11 order kept", v, held[i]);
    end
    rd(3'd5, v); chk(v[0] == 1'b0, "R7 drained", int'(v[0]), 0);

    send_rx(8'h81, 8'h03, 0, 0);
    wr(3'd2, 8'h03);
    rd(3'd5, v); chk(v[0] == 1'b0, "R7 receive clear", int'(v[0]), 0);

    wr(3'd3, 8'h83);
    send_rx(8'h42, 8'h03, 0, 0);
    rd(3'd0, v); chk(v == 8'(DIV), "R1 remapped read", v, DIV);
    wr(3'd3, 8'h03);
    rd(3'd0, v); chk(v == 8'h42, "R1 remapped read removes nothing", v, 8'h42);

    wr(3'd1, 8'h01); idle(3);
    chk(irq === 1'b0, "R12 no data no irq", int'(irq), 0);
    send_rx(8'h17, 8'h03, 0, 0);
    chk(irq === 1'b1, "R12 data irq", int'(irq), 1);
    rd(3'd0, v); idle(3);
    chk(irq === 1'b0, "R12 irq drops after read", int'(irq), 0);
    wr(3'd1, 8'h02); idle(3);
    chk(irq === 1'b1, "R12 transmit-empty irq", int'(irq), 1);
    wr(3'd1, 8'h00); idle(3);
    chk(irq === 1'b0, "R12 masked", int'(irq), 0);

    wr(3'd3, 8'h43); idle(3);
    for (int i = 0; i < 4; i++) begin
      idle(BIT);
      chk(txd === 1'b0, "R6 break holds low", int'(txd), 0);
    end
    wr(3'd3, 8'h03); idle(3);
    chk(txd === 1'b1, "R6 line released", int'(txd), 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule